// File: doc/BRIEF.md
# SPI-4 Receive Element Allocator

This block is the receive-control part of a packet interface. It takes each control word framed by the receive-control strobe, places it in a holding register, and clears the payload checksum accumulator in the following cycle through a one-cycle pulse. It then sorts the word by its 2-bit type field. Idle and training words are dropped. Any other word claims one fixed-size element of the receive buffer, so the burst that follows has somewhere to land.

A bitmap tracks which elements are free. Allocation takes the lowest-numbered free element. A release port returns elements to the pool. If no element is free, the burst is dropped and an overflow flag latches until software writes one to clear it. A flow-control output asserts whenever the number of free elements is below a programmable threshold. That output is fed back to the sender.

The control-word input has no ready signal, because the line cannot be stalled. A word is accepted on every cycle in which `ctl_valid` is high, and strobes may arrive on back-to-back cycles. The allocation result is a one-cycle valid pulse with no back-pressure. The downstream writer must take it in the cycle it appears.

Top module: `rx_elem_alloc`

## Requirements
- R1: After reset every element is free, `free_count` equals NUM_ELEM, `alloc_valid` and `drop` are low, and `ovf_flag` is clear.
- R2: A word presented with `ctl_valid` high appears on `cw_hold` one cycle later, and `csum_clr` is high for exactly that cycle.
- R3: The type field is bits [TYPE_MSB:TYPE_MSB-1] of the control word. Type TYPE_IDLE (default 2'b00) and type TYPE_TRAIN (default 2'b11) never allocate, never drop, and leave `free_count` and `ovf_flag` unchanged.
- R4: Any other type pulses `alloc_valid` two cycles after the strobe when an element is free. `alloc_idx` gives the lowest-numbered free element and `alloc_word` gives the control word. That element is then no longer free.
- R5: A word of another type that finds no element free pulses `drop` two cycles after the strobe instead of `alloc_valid`, and sets `ovf_flag` in that same cycle.
- R6: `ovf_flag` stays set until `ovf_clr` is high at a clock edge. If a new overflow occurs at the same edge as the clear, the flag stays set.
- R7: `rel_valid` with `rel_idx` returns an allocated element to the pool at the next edge. Releasing an element that is already free has no effect.
- R8: `free_count` always equals the number of free elements. An allocation and a release at the same edge leave it unchanged. The allocation decision uses the pool as it was before that edge.
- R9: `fc_assert` is high exactly when `free_count` < `fc_thresh`, and follows a change of either signal in the same cycle.
- R10: Strobes on consecutive cycles are each handled. Two data words in a row receive the two lowest free elements in order, in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Receive-control strobe; word accepted when high |
| ctl_word | input | CW_W | Incoming control word |
| cw_hold | output | CW_W | Holding register contents |
| csum_clr | output | 1 | One-cycle checksum accumulator clear |
| alloc_valid | output | 1 | Element allocated this cycle |
| alloc_idx | output | IDX_W | Index of allocated element |
| alloc_word | output | CW_W | Control word that opened the element |
| drop | output | 1 | Burst discarded for lack of an element |
| rel_valid | input | 1 | Release request |
| rel_idx | input | IDX_W | Element to release |
| fc_thresh | input | CNT_W | Flow-control threshold |
| fc_assert | output | 1 | Free count below threshold |
| free_count | output | CNT_W | Number of free elements |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_clr | input | 1 | Write-one-to-clear for `ovf_flag` |

## Verification
The holding register and the checksum clear are due one edge after the strobe. The allocation pulse, drop pulse, overflow flag and free count are due two edges after it. A release shows in the count one edge after it is presented. The bench drives inputs on the falling edge and reads each result at the falling edge that follows the rising edge on which that result is due. It counts the edges explicitly for every stimulus. Flow control is combinational on the count, so it is swept across every threshold value after a short settle delay, with no extra edge.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_SKIP = 2'd1,
    CLS_DATA = 2'd2
  } cw_class_e;
endpackage

// File: rtl/rxa_cw_capture.sv
module rxa_cw_capture
  import rxa_pkg::*;
#(
  parameter int CW_W       = 16,
  parameter int TYPE_MSB   = CW_W - 1,
  parameter logic [1:0] TYPE_IDLE  = 2'b00,
  parameter logic [1:0] TYPE_TRAIN = 2'b11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [CW_W-1:0] word_in,
  output logic [CW_W-1:0] hold_word,
  output cw_class_e       hold_cls,
  output logic            csum_clr
);
  logic       hold_vld;
  logic [1:0] hold_type;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_word <= '0;
      hold_vld  <= 1'b0;
      csum_clr  <= 1'b0;
    end else begin
      hold_vld <= strobe;
      csum_clr <= strobe;
      if (strobe) hold_word <= word_in;
    end
  end

  assign hold_type = hold_word[TYPE_MSB -: 2];

  always_comb begin
    if (!hold_vld)
      hold_cls = CLS_NONE;
    else if (hold_type == TYPE_IDLE || hold_type == TYPE_TRAIN)
      hold_cls = CLS_SKIP;
    else
      hold_cls = CLS_DATA;
  end
endmodule

// File: rtl/rxa_pick_lowest.sv
module rxa_pick_lowest #(
  parameter int N    = 8,
  parameter int IW   = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rxa_pool.sv
module rxa_pool #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [IW-1:0] take_idx,
  input  logic          give,
  input  logic [IW-1:0] give_idx,
  output logic [N-1:0]  free_map,
  output logic [CW-1:0] free_cnt
);
  logic give_ok;

  // a release counts only when the element is actually held
  assign give_ok = give && !free_map[give_idx];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        free_map[g] <= 1'b1;
      else if (take && take_idx == IW'(g))
        free_map[g] <= 1'b0;
      else if (give_ok && give_idx == IW'(g))
        free_map[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      free_cnt <= CW'(N);
    else
      free_cnt <= free_cnt + CW'(give_ok) - CW'(take);
  end
endmodule

// File: rtl/rx_elem_alloc.sv
module rx_elem_alloc
  import rxa_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int CW_W     = 16,
  parameter int TYPE_MSB = CW_W - 1,
  parameter logic [1:0] TYPE_IDLE  = 2'b00,
  parameter logic [1:0] TYPE_TRAIN = 2'b11,
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int CNT_W = $clog2(NUM_ELEM + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_valid,
  input  logic [CW_W-1:0]  ctl_word,
  output logic [CW_W-1:0]  cw_hold,
  output logic             csum_clr,
  output logic             alloc_valid,
  output logic [IDX_W-1:0] alloc_idx,
  output logic [CW_W-1:0]  alloc_word,
  output logic             drop,
  input  logic             rel_valid,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [CNT_W-1:0] fc_thresh,
  output logic             fc_assert,
  output logic [CNT_W-1:0] free_count,
  output logic             ovf_flag,
  input  logic             ovf_clr
);
  cw_class_e          w_cls;
  logic [CW_W-1:0]    w_hold;
  logic [NUM_ELEM-1:0] w_map;
  logic               w_found;
  logic [IDX_W-1:0]   w_pick;
  logic               w_take;
  logic               w_starve;

  rxa_cw_capture #(
    .CW_W(CW_W), .TYPE_MSB(TYPE_MSB),
    .TYPE_IDLE(TYPE_IDLE), .TYPE_TRAIN(TYPE_TRAIN)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .strobe(ctl_valid), .word_in(ctl_word),
    .hold_word(w_hold), .hold_cls(w_cls), .csum_clr(csum_clr)
  );

  rxa_pick_lowest #(.N(NUM_ELEM), .IW(IDX_W)) u_pick (
    .req(w_map), .found(w_found), .idx(w_pick)
  );

  assign w_take   = (w_cls == CLS_DATA) && w_found;
  assign w_starve = (w_cls == CLS_DATA) && !w_found;

  rxa_pool #(.N(NUM_ELEM), .IW(IDX_W), .CW(CNT_W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .take(w_take), .take_idx(w_pick),
    .give(rel_valid), .give_idx(rel_idx),
    .free_map(w_map), .free_cnt(free_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_valid <= 1'b0;
      alloc_idx   <= '0;
      alloc_word  <= '0;
      drop        <= 1'b0;
      ovf_flag    <= 1'b0;
    end else begin
      alloc_valid <= w_take;
      drop        <= w_starve;
      if (w_take) begin
        alloc_idx  <= w_pick;
        alloc_word <= w_hold;
      end
      if (w_starve)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end

  assign cw_hold   = w_hold;
  assign fc_assert = free_count < fc_thresh;
endmodule

// File: rtl/rx_elem_alloc_chk.sv
module rx_elem_alloc_chk
  import rxa_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_valid,
  input logic             csum_clr,
  input cw_class_e        cls,
  input logic             any_free,
  input logic [N-1:0]     free_map,
  input logic [CNT_W-1:0] free_count,
  input logic             alloc_valid,
  input logic             drop,
  input logic             ovf_flag,
  input logic             ovf_clr
);
  assert_csum_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> csum_clr);
  assert_skip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_SKIP) |=> (!alloc_valid && !drop));
  assert_data_alloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_DATA && any_free) |=> alloc_valid);
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CLS_DATA && !any_free) |=> (drop && ovf_flag));
  assert_alloc_xor_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_valid && drop));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  assert_count_tracks_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (int'(free_count) == $countones(free_map)));
endmodule

bind rx_elem_alloc rx_elem_alloc_chk #(.N(NUM_ELEM), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .csum_clr(csum_clr),
  .cls(w_cls), .any_free(w_found), .free_map(w_map), .free_count(free_count),
  .alloc_valid(alloc_valid), .drop(drop), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
);

// File: tb/rx_elem_alloc_bench.sv
module rx_elem_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int CWW = 8;
  localparam int IW  = 2;
  localparam int CNW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_valid = 1'b0;
  logic [CWW-1:0] ctl_word = '0;
  logic [CWW-1:0] cw_hold;
  logic csum_clr, alloc_valid, drop, fc_assert, ovf_flag;
  logic [IW-1:0] alloc_idx;
  logic [CWW-1:0] alloc_word;
  logic rel_valid = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic [CNW-1:0] fc_thresh = '0;
  logic [CNW-1:0] free_count;
  logic ovf_clr = 1'b0;

  int vectors = 0;
  int fails = 0;
  logic [N-1:0] mfree;
  int  mcnt;
  bit  movf;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_elem_alloc #(.NUM_ELEM(N), .CW_W(CWW)) u_rx_elem_alloc (
    .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_word(ctl_word),
    .cw_hold(cw_hold), .csum_clr(csum_clr), .alloc_valid(alloc_valid),
    .alloc_idx(alloc_idx), .alloc_word(alloc_word), .drop(drop),
    .rel_valid(rel_valid), .rel_idx(rel_idx), .fc_thresh(fc_thresh),
    .fc_assert(fc_assert), .free_count(free_count), .ovf_flag(ovf_flag),
    .ovf_clr(ovf_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (mfree[i]) return i;
    return -1;
  endfunction

  // flow control swept over every threshold value (R9), then count (R8)
  task automatic check_count();
    for (int t = 0; t < (1 << CNW); t++) begin
      fc_thresh = CNW'(t);
      #1;
      chk(fc_assert == (mcnt < t), "R9 fc_assert", int'(fc_assert), int'(mcnt < t));
    end
    fc_thresh = '0;
    chk(int'(free_count) == mcnt, "R8 free_count", int'(free_count), mcnt);
    chk(ovf_flag == movf, "R6 ovf_flag", int'(ovf_flag), int'(movf));
  endtask

  // one strobe, optional release landing on the same edge as the allocation
  task automatic send_cw(input logic [CWW-1:0] w, input bit with_rel, input int ridx);
    logic [1:0] ty;
    bit is_data, exp_alloc;
    int exp_idx;
    @(negedge clk);
    ctl_valid = 1'b1; ctl_word = w;
    @(negedge clk);
    ctl_valid = 1'b0;
    chk(csum_clr == 1'b1, "R2 csum_clr", int'(csum_clr), 1);
    chk(cw_hold == w, "R2 cw_hold", int'(cw_hold), int'(w));
    ty = w[CWW-1 -: 2];
    is_data = (ty != 2'b00) && (ty != 2'b11);
    exp_idx = lowest_free();
    exp_alloc = is_data && (exp_idx >= 0);
    if (with_rel) begin rel_valid = 1'b1; rel_idx = IW'(ridx); end
    @(negedge clk);
    rel_valid = 1'b0;
    chk(csum_clr == 1'b0, "R2 csum_clr one cycle", int'(csum_clr), 0);
    chk(alloc_valid == exp_alloc, is_data ? "R4 alloc_valid" : "R3 no alloc",
        int'(alloc_valid), int'(exp_alloc));
    chk(drop == (is_data && !exp_alloc), is_data ? "R5 drop" : "R3 no drop",
        int'(drop), int'(is_data && !exp_alloc));
    if (exp_alloc) begin
      chk(int'(alloc_idx) == exp_idx, "R4 alloc_idx lowest", int'(alloc_idx), exp_idx);
      chk(alloc_word == w, "R4 alloc_word", int'(alloc_word), int'(w));
      mfree[exp_idx] = 1'b0; mcnt--;
    end
    if (is_data && !exp_alloc) movf = 1'b1;
    if (with_rel && !mfree[ridx]) begin mfree[ridx] = 1'b1; mcnt++; end
    check_count();
  endtask

  task automatic release_elem(input int idx);
    @(negedge clk);
    rel_valid = 1'b1; rel_idx = IW'(idx);
    @(negedge clk);
    rel_valid = 1'b0;
    if (!mfree[idx]) begin mfree[idx] = 1'b1; mcnt++; end
    check_count();
  endtask

  task automatic clear_ovf();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    movf = 1'b0;
    check_count();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    mfree = '1; mcnt = N; movf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(alloc_valid == 1'b0, "R1 alloc_valid", int'(alloc_valid), 0);
    chk(drop == 1'b0, "R1 drop", int'(drop), 0);
    chk(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);
    chk(int'(free_count) == N, "R1 free_count", int'(free_count), N);
    check_count();

    // R3 R4 R5: every type code with varied payload bits, rounds until full and past
    for (int r = 0; r < 3; r++)
      for (int ty = 0; ty < 4; ty++)
        send_cw({ty[1:0], 6'(r * 11 + ty)}, 1'b0, 0);

    // R6 clear, then clear at the same edge as a new overflow
    clear_ovf();
    @(negedge clk);
    ctl_valid = 1'b1; ctl_word = 8'h55;
    @(negedge clk);
    ctl_valid = 1'b0; ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    movf = 1'b1;
    chk(drop == 1'b1, "R5 drop when full", int'(drop), 1);
    chk(ovf_flag == 1'b1, "R6 set wins over clear", int'(ovf_flag), 1);
    clear_ovf();

    // R7 release out of order, lowest index picked afterwards
    release_elem(2);
    release_elem(2);              // already free: no effect
    release_elem(0);
    send_cw(8'h41, 1'b0, 0);      // expect index 0
    send_cw(8'h82, 1'b0, 0);      // expect index 2

    // R8 full pool with a release at the same edge: still dropped, count rises
    send_cw(8'h43, 1'b1, 1);
    clear_ovf();
    // R8 allocation and release at one edge: count unchanged
    send_cw(8'h44, 1'b1, 3);

    // R10 back-to-back data words
    release_elem(0);
    release_elem(2);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_word = 8'h61;
    @(negedge clk);
    ctl_word = 8'h92;
    @(negedge clk);
    ctl_valid = 1'b0;
    chk(alloc_valid && alloc_idx == 2'd0, "R10 first alloc idx", int'(alloc_idx), 0);
    chk(alloc_word == 8'h61, "R10 first word", int'(alloc_word), 'h61);
    @(negedge clk);
    chk(alloc_valid && alloc_idx == 2'd2, "R10 second alloc idx", int'(alloc_idx), 2);
    chk(alloc_word == 8'h92, "R10 second word", int'(alloc_word), 'h92);
    mfree[0] = 1'b0; mfree[2] = 1'b0; mcnt -= 2;
    check_count();

    // drain everything and confirm full recovery
    for (int i = 0; i < N; i++) release_elem(i);
    chk(int'(free_count) == N, "R7 all returned", int'(free_count), N);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule